// File: doc/BRIEF.md
# SMBus Byte-Protocol Register Target

This block is a bus target that lets an SMBus host read and write a small internal register file. It never starts a transfer. It accepts four transaction shapes only. Write Byte carries a command byte that selects a register and then one data byte. Read Byte carries a command byte, then a repeated START with the read address, and the target returns one byte. Send Byte carries only the command byte, which moves the register pointer. Receive Byte returns the register at the current pointer. The pointer is kept between transactions, so the last two shapes work on their own.

The block samples SCL and SDA with the system clock. Both lines pass through a two-flop synchroniser and a glitch filter before any edge is detected. SDA is driven open-drain: `sda_oe` high means the block pulls the line low. The system clock must be much faster than SCL, which runs from 10 kHz to 400 kHz. A few tens of system clocks per SCL phase is enough. `FILT_LEN` must be at least 2 and `NUM_REGS` a power of two of at least 2.

Top module: `smb_byte_target`

## Requirements
- R1: After reset the block does not drive SDA, every register holds 0x00 and the pointer selects register 0.
- R2: An address byte whose upper seven bits equal `SLAVE_ADDR` is acknowledged by pulling SDA low for the ninth SCL pulse. This holds for both values of the direction bit, bit 0 (0 = write, 1 = read).
- R3: An address byte that does not match gets no acknowledge. The block then leaves SDA released, and ignores every further byte until the next START or STOP, so no register changes.
- R4: In a write transaction the first byte after the address sets the pointer. A second byte is stored in the register selected by the low log2(`NUM_REGS`) bits of the command, and both bytes are acknowledged.
- R5: Send Byte sets the pointer without changing any register. Each later Receive Byte returns the register at that pointer, and the pointer is kept across transactions.
- R6: Read Byte returns the register selected by its command byte, most significant bit first, after a repeated START with the read address.
- R7: After sending its eight data bits the block releases SDA, whether the host answers with ACK or NACK, and stays released until the next START or STOP.
- R8: A third byte in a write transaction is not acknowledged and changes no register.
- R9: A pulse on SCL shorter than `FILT_LEN` system clocks has no effect on the received data.
- R10: START and STOP are SDA falling and rising edges while SCL is high. A STOP in the middle of a byte aborts the transaction without changing the pointer.
- R11: The block changes its SDA drive only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level as seen at the pin |
| sda_i | input | 1 | SDA line level as seen at the pin |
| sda_oe | output | 1 | High to pull SDA low (open-drain enable) |

## Verification
Each of the four transaction shapes runs against registers that hold different values. This shows whether a returned byte comes from the command byte, from the stored pointer, or from a stale register. Some bytes are sent to a foreign address and some are extra bytes after the data byte. Comparing the acknowledge bit and the later read-back shows whether the block really ignored them. Commands above the register count check the index wrap. A transaction cut short by a STOP checks that the pointer is left alone. Single-cycle SCL spikes inside bits check that the filter, and not the bit decoder, absorbs noise. A continuous monitor flags any change of the SDA drive while SCL is high.

// File: rtl/smbt_pkg.sv
// Package: shared types for the SMBus byte-protocol target.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package smbt_pkg;

    // Bus engine states
    typedef enum logic [2:0] {
        ST_IDLE,   // no transaction, SDA released
        ST_RX,     // shifting in a byte from the host
        ST_ACK,    // holding SDA low for the ninth pulse
        ST_TX,     // shifting a register byte out
        ST_WAIT    // released, ignoring bits until START/STOP
    } eng_state_t;

    // Which byte of the transaction is being received
    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_DATA,
        K_EXTRA
    } byte_kind_t;

endpackage

// File: rtl/smbt_deglitch.sv
// Module: smbt_deglitch
// Brings one asynchronous bus line into the clock domain through two flops,
// then only lets the output follow a level held for FILT_LEN samples.
// Assumes: FILT_LEN >= 2; the idle level of the line is high.
module smbt_deglitch #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;

    // Two-stage synchroniser, reset to the idle level
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_i};
    end

    // Count consecutive samples that differ from the output; flip when enough
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            line_o <= 1'b1;
        end else if (sync_q[1] != line_o) begin
            if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
                line_o <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    // R9: a new output level must have been present at the synchroniser for two samples
    assert_filter_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> ($past(sync_q[1]) == line_o && $past(sync_q[1], 2) == line_o));

endmodule

// File: rtl/smbt_regfile.sv
// Module: smbt_regfile
// Register file seen by the host: one synchronous write port and one
// combinational read port, all registers cleared by reset.
// Assumes: NUM_REGS is a power of two, at least 2.
module smbt_regfile #(
    parameter int NUM_REGS = 16,
    parameter int DW       = 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem_q [NUM_REGS];

    // One storage word per register index
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Clear on reset, load when this index is written
        always_ff @(posedge clk) begin
            if (!rst_n)                         mem_q[g] <= '0;
            else if (we && widx == IDX_W'(g))   mem_q[g] <= wdata;
        end

        // R8/R3: a register not addressed by a write keeps its value
        assert_untouched_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && widx == IDX_W'(g)) |=> $stable(mem_q[g]));
    end

    // Combinational read at the pointer
    assign rdata = mem_q[ridx];

endmodule

// File: rtl/smbt_bus_engine.sv
// Module: smbt_bus_engine
// Decodes START/STOP and bits from the filtered lines, matches the address,
// keeps the register pointer, acknowledges bytes and shifts read data out.
// Assumes: lines already synchronised and filtered; SCL much slower than clk.
module smbt_bus_engine
    import smbt_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h3A,
    parameter int         IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_f,
    input  logic             sda_f,
    input  logic [7:0]       rdata,
    output logic [IDX_W-1:0] ptr,
    output logic             we,
    output logic [7:0]       wdata,
    output logic             sda_oe
);
    eng_state_t  state;
    byte_kind_t  kind;
    logic        scl_q, sda_q;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg, txsh;
    logic        go_tx;
    logic        scl_rise, scl_fall, start_ev, stop_ev, byte_done, addr_hit;

    // Previous filtered line levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Bus events derived from the filtered lines
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_ev  = scl_f & scl_q & sda_q & ~sda_f;
        stop_ev   = scl_f & scl_q & ~sda_q & sda_f;
        byte_done = scl_fall && (bitcnt == 4'd8);
        addr_hit  = (shreg[7:1] == SLAVE_ADDR);
    end

    // Register write happens as the data byte completes
    assign we    = (state == ST_RX) && byte_done && (kind == K_DATA);
    assign wdata = shreg;

    // Transaction sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind   <= K_ADDR;
            bitcnt <= '0;
            shreg  <= '0;
            txsh   <= '0;
            sda_oe <= 1'b0;
            ptr    <= '0;
            go_tx  <= 1'b0;
        end else if (start_ev) begin
            state  <= ST_RX;
            kind   <= K_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (stop_ev) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_f};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        case (kind)
                            K_ADDR: begin
                                if (addr_hit) begin
                                    state  <= ST_ACK;
                                    sda_oe <= 1'b1;
                                    go_tx  <= shreg[0];
                                    kind   <= K_CMD;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end
                            K_CMD: begin
                                ptr    <= shreg[IDX_W-1:0];
                                state  <= ST_ACK;
                                sda_oe <= 1'b1;
                                go_tx  <= 1'b0;
                                kind   <= K_DATA;
                            end
                            K_DATA: begin
                                state  <= ST_ACK;
                                sda_oe <= 1'b1;
                                go_tx  <= 1'b0;
                                kind   <= K_EXTRA;
                            end
                            default: state <= ST_WAIT;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (go_tx) begin
                            state  <= ST_TX;
                            sda_oe <= ~rdata[7];
                            txsh   <= {rdata[6:0], 1'b0};
                            bitcnt <= 4'd1;
                        end else begin
                            state  <= ST_RX;
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            state  <= ST_WAIT;
                            sda_oe <= 1'b0;
                        end else begin
                            sda_oe <= ~txsh[7];
                            txsh   <= {txsh[6:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R11: SDA drive only moves while the filtered clock is low
    assert_sda_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R10: a START re-arms reception of an address byte with SDA released
    assert_start_rearms_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_RX && kind == K_ADDR && bitcnt == 4'd0 && !sda_oe));

    // R10: a STOP ends the transaction and releases SDA
    assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE && !sda_oe));

    // R5: the pointer moves only when a command byte completes
    assert_ptr_on_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> $past(state == ST_RX && kind == K_CMD && byte_done));

    // R3: in the ignore state SDA is never driven
    assert_wait_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT || state == ST_IDLE) |-> !sda_oe);

    // Bit counter never passes one full byte
    assert_bitcnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd8);

endmodule

// File: rtl/smb_byte_target.sv
// Module: smb_byte_target
// Top level: filters both bus lines, runs the bus engine and holds the
// register file the host reads and writes.
// Assumes: SDA pad is open-drain, sda_oe high pulls it low.
module smb_byte_target #(
    parameter logic [6:0] SLAVE_ADDR = 7'h3A,
    parameter int         NUM_REGS   = 16,
    parameter int         FILT_LEN   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [1:0]       raw_lines, clean_lines;
    logic [IDX_W-1:0] ptr;
    logic             we;
    logic [7:0]       wdata, rdata;

    assign raw_lines = {scl_i, sda_i};

    // One identical filter per bus line
    for (genvar l = 0; l < 2; l++) begin : g_line
        smbt_deglitch #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[l]),
            .line_o (clean_lines[l])
        );
    end

    smbt_bus_engine #(.SLAVE_ADDR(SLAVE_ADDR), .IDX_W(IDX_W)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_f  (clean_lines[1]),
        .sda_f  (clean_lines[0]),
        .rdata  (rdata),
        .ptr    (ptr),
        .we     (we),
        .wdata  (wdata),
        .sda_oe (sda_oe)
    );

    smbt_regfile #(.NUM_REGS(NUM_REGS), .DW(8)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .widx  (ptr),
        .wdata (wdata),
        .ridx  (ptr),
        .rdata (rdata)
    );

endmodule

// File: tb/smb_byte_target_test.sv
// Bench: plays an SMBus host; read bytes go through an expected/observed scoreboard.
module smb_byte_target_test;
    localparam int CLK_P = 10;
    localparam int Q     = 25;            // system clocks per quarter SCL bit
    localparam logic [7:0] AW = 8'h74;    // address 0x3A, write
    localparam logic [7:0] AR = 8'h75;    // address 0x3A, read

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_checks = 0, n_fail = 0, viol = 0;
    logic [7:0] exp_q[$], obs_q[$];
    string      req_q[$];

    always #(CLK_P/2) clk = ~clk;

    smb_byte_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor: pairs each observed byte with its expected value
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] o, e;
                string r;
                o = obs_q.pop_front(); e = exp_q.pop_front(); r = req_q.pop_front();
                chk(o == e, r, o, e);
            end
        end
    end

    // R11: SDA drive must not change while SCL is high at the pins
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && sda_oe != oe_prev) viol++;
        oe_prev <= sda_oe;
    end

    task automatic bit_cyc(input logic v, input bit glitch, output logic s);
        sda_m = v;
        if (glitch) begin
            waitq(8); scl_m = 1'b1; waitq(1); scl_m = 1'b0; waitq(Q - 9);
        end else waitq(Q);
        scl_m = 1'b1; waitq(Q);
        s = sda_bus; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic do_start();
        sda_m = 1'b1; waitq(Q); scl_m = 1'b1; waitq(Q);
        sda_m = 1'b0; waitq(Q); scl_m = 1'b0; waitq(Q);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; waitq(Q); scl_m = 1'b1; waitq(Q);
        sda_m = 1'b1; waitq(2*Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit glitch, output bit acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], glitch, s);
        bit_cyc(1'b1, glitch, s);
        acked = (s == 1'b0);
    endtask

    task automatic rd_byte(input logic [7:0] exp, input string req, input bit nack);
        logic s;
        logic [7:0] b;
        exp_q.push_back(exp); req_q.push_back(req);
        for (int i = 7; i >= 0; i--) begin
            bit_cyc(1'b1, 1'b0, s);
            b[i] = s;
        end
        obs_q.push_back(b);
        sda_m = nack;
        waitq(Q); scl_m = 1'b1; waitq(Q);
        chk(sda_oe == 1'b0, "R7 released in host ack slot", sda_oe, 0);
        waitq(Q); scl_m = 1'b0; waitq(Q);
    endtask

    task automatic write_reg(input logic [7:0] cmd, input logic [7:0] d, input bit glitch, input string req);
        bit a;
        do_start();
        wr_byte(AW, glitch, a);  chk(a, "R2 write address acked", a, 1);
        wr_byte(cmd, glitch, a); chk(a, {req, " command acked"}, a, 1);
        wr_byte(d, glitch, a);   chk(a, {req, " data acked"}, a, 1);
        do_stop();
    endtask

    task automatic read_reg(input logic [7:0] cmd, input logic [7:0] exp, input string req);
        bit a;
        do_start();
        wr_byte(AW, 1'b0, a);  chk(a, {req, " address acked"}, a, 1);
        wr_byte(cmd, 1'b0, a); chk(a, {req, " command acked"}, a, 1);
        do_start();
        wr_byte(AR, 1'b0, a);  chk(a, "R2 read address acked", a, 1);
        rd_byte(exp, req, 1'b1);
        do_stop();
    endtask

    task automatic send_ptr(input logic [7:0] cmd);
        bit a;
        do_start();
        wr_byte(AW, 1'b0, a);  chk(a, "R5 send byte address acked", a, 1);
        wr_byte(cmd, 1'b0, a); chk(a, "R5 send byte command acked", a, 1);
        do_stop();
    endtask

    task automatic recv(input logic [7:0] exp, input string req);
        bit a;
        do_start();
        wr_byte(AR, 1'b0, a); chk(a, "R2 receive address acked", a, 1);
        rd_byte(exp, req, 1'b1);
        do_stop();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit a;
        logic s;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        waitq(4);
        chk(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);
        recv(8'h00, "R1 receive at reset pointer");

        write_reg(8'h05, 8'hA5, 1'b0, "R4");
        write_reg(8'h0C, 8'h3C, 1'b0, "R4");
        read_reg(8'h05, 8'hA5, "R6 read byte reg 5");
        read_reg(8'h0C, 8'h3C, "R6 read byte reg 12");

        send_ptr(8'h0C);
        recv(8'h3C, "R5 receive after send byte");
        recv(8'h3C, "R5 pointer persists");

        // R3: foreign address and its following bytes are ignored
        do_start();
        wr_byte({7'h22, 1'b0}, 1'b0, a); chk(!a, "R3 foreign address not acked", a, 0);
        wr_byte(8'h05, 1'b0, a);         chk(!a, "R3 byte after foreign address", a, 0);
        wr_byte(8'hFF, 1'b0, a);         chk(!a, "R3 data after foreign address", a, 0);
        do_stop();
        read_reg(8'h05, 8'hA5, "R3 register unchanged");

        // R8: third byte of a write is refused and stored nowhere
        do_start();
        wr_byte(AW, 1'b0, a);    chk(a, "R8 address acked", a, 1);
        wr_byte(8'h07, 1'b0, a); chk(a, "R8 command acked", a, 1);
        wr_byte(8'h11, 1'b0, a); chk(a, "R8 data acked", a, 1);
        wr_byte(8'h99, 1'b0, a); chk(!a, "R8 extra byte not acked", a, 0);
        do_stop();
        read_reg(8'h07, 8'h11, "R8 register keeps data byte");
        read_reg(8'h08, 8'h00, "R8 next register untouched");

        // R4: index wraps on the low bits of the command
        write_reg(8'h13, 8'h5A, 1'b0, "R4 wrap");
        read_reg(8'h03, 8'h5A, "R4 command 0x13 maps to register 3");

        // R10: STOP in the middle of a command byte leaves the pointer alone
        send_ptr(8'h0C);
        do_start();
        wr_byte(AW, 1'b0, a); chk(a, "R10 address acked", a, 1);
        bit_cyc(1'b0, 1'b0, s); bit_cyc(1'b0, 1'b0, s);
        bit_cyc(1'b0, 1'b0, s); bit_cyc(1'b0, 1'b0, s);
        do_stop();
        recv(8'h3C, "R10 pointer kept after aborted byte");

        // R9: single-cycle SCL spikes inside every bit are filtered out
        write_reg(8'h09, 8'hC3, 1'b1, "R9");
        read_reg(8'h09, 8'hC3, "R9 glitched write stored intact");

        // R7: host ACKs the byte and keeps clocking; the line stays released
        send_ptr(8'h05);
        do_start();
        wr_byte(AR, 1'b0, a); chk(a, "R7 read address acked", a, 1);
        rd_byte(8'hA5, "R7 first byte", 1'b0);
        rd_byte(8'hFF, "R7 line released after byte", 1'b1);
        do_stop();

        waitq(10);
        chk(exp_q.size() == 0 && obs_q.size() == 0, "scoreboard drained", obs_q.size(), 0);
        chk(viol == 0, "R11 SDA drive stable while SCL high", viol, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule